// File: doc/BRIEF.md
# Branch and PHI Edge-Tag Unit

This block resolves control flow for a processor whose instruction stream is in SSA form. Each cycle it may receive one decoded instruction: an operation code, the branch or jump fields, the PHI fields, a condition value read from the SSA register file, and the sequential next address worked out by the fetch logic. From these it keeps the program counter and a predecessor-edge tag register. The tag register records which control-flow edge execution last travelled along.

PHI nodes are resolved in hardware. Every taken branch or jump writes its edge tag into the tag register. A PHI instruction compares that tag with the tag attached to each of its two sources, and the unit returns the SSA ID that the register file should read for the PHI destination. Return and halt end execution. The unit raises a sticky completion flag, freezes the PC, and for a return presents the ID of the returned value.

Top module: `edge_flow_unit`

## Requirements
- R1: After reset, `pc` is 0, `pred_tag` is 0, `done` is 0 and `ret_id` is 0.
- R2: A branch (`op` = 1) accepted while `instr_valid` is high and `done` is low loads `tgt_true` into `pc` and `tag_true` into `pred_tag` when any bit of `cond_value` is set. If `cond_value` is zero it loads `tgt_false` and `tag_false` instead. The new values are visible after the next rising clock edge.
- R3: A jump (`op` = 2) loads `tgt_true` into `pc` and `tag_true` into `pred_tag` whatever `cond_value` holds.
- R4: Every other accepted code other than return and halt loads `seq_pc` into `pc` and leaves `pred_tag` unchanged. This covers no-op (`op` = 0), PHI (`op` = 4) and the unused codes 6 to 15.
- R5: While `op` = 4 and `instr_valid` is high, `phi_src_sel` equals `phi_src_a` when `pred_tag` equals `phi_tag_a`, and equals `phi_src_b` when it matches only `phi_tag_b`. When both tags match, source A wins. The output is combinational in the same cycle.
- R6: While `op` = 4 and `instr_valid` is high, if `pred_tag` matches neither PHI tag, `phi_miss` is 1 and `phi_src_sel` equals `phi_src_a`. `phi_miss` is 0 in every other case.
- R7: A return (`op` = 3) sets `done` and captures `ret_src` into `ret_id`, and `pc` keeps its value.
- R8: A halt (`op` = 5) sets `done` and keeps `pc`, and `ret_id` keeps its value.
- R9: Once `done` is 1, it stays 1 and every further instruction is ignored: `pc`, `pred_tag` and `ret_id` do not change until reset.
- R10: While `instr_valid` is low, `pc`, `pred_tag`, `done` and `ret_id` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | A decoded instruction is present this cycle |
| op | input | 4 | Operation code (0 no-op, 1 branch, 2 jump, 3 return, 4 PHI, 5 halt) |
| cond_value | input | 32 | Condition value read for a branch |
| seq_pc | input | 16 | Sequential next address from fetch |
| tgt_true | input | 16 | Branch taken target, or jump target |
| tgt_false | input | 16 | Branch not-taken target |
| tag_true | input | 8 | Edge tag for taken branch, or for jump |
| tag_false | input | 8 | Edge tag for not-taken branch |
| phi_src_a | input | 8 | PHI source A SSA ID |
| phi_src_b | input | 8 | PHI source B SSA ID |
| phi_tag_a | input | 8 | Edge tag paired with source A |
| phi_tag_b | input | 8 | Edge tag paired with source B |
| ret_src | input | 8 | SSA ID of the value being returned |
| pc | output | 16 | Program counter |
| pred_tag | output | 8 | Predecessor-edge tag register |
| phi_src_sel | output | 8 | SSA ID chosen for the PHI destination |
| phi_miss | output | 1 | PHI tag matched no source |
| done | output | 1 | Execution ended by return or halt |
| ret_id | output | 8 | SSA ID captured by return |

## Verification
The hardest situations to reach are the PHI cases. They depend on the tag register, which can only be set through an earlier branch or jump. The stimulus therefore steers `pred_tag` first, using a taken branch, a not-taken branch and a jump with chosen tags. It then issues PHI instructions whose tags match A, match B, match both, or match neither. The condition word is also driven with only its top bit set, so a zero detector that misses the upper bits is caught. After a return, a jump is sent to show that the frozen state ignores it. Reset is then applied again so that halt can be checked with a known `ret_id`.

// File: rtl/edge_flow_pkg.sv
package edge_flow_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      FLOW_NOP  = 4'd0,
      FLOW_BR   = 4'd1,
      FLOW_JMP  = 4'd2,
      FLOW_RET  = 4'd3,
      FLOW_PHI  = 4'd4,
      FLOW_HALT = 4'd5
   } flow_op_e;

   typedef struct packed {
      logic advance;   // write pc
      logic tag_wr;    // write pred_tag
      logic finish;    // set done
      logic ret_cap;   // capture ret_id
   } flow_ctl_t;

endpackage

// File: rtl/edge_flow_cond.sv
// Zero detection on the branch condition word.
module edge_flow_cond #(
   parameter int DATA_W  = 32,
   parameter int SPLIT_W = 16
) (
   input  logic [DATA_W-1:0] value,
   output logic              nonzero
);
   localparam int LANES = (DATA_W + SPLIT_W - 1) / SPLIT_W;
   localparam int PAD_W = LANES * SPLIT_W;

   initial begin
      if (DATA_W < 1)  $error("edge_flow_cond: DATA_W must be positive");
      if (SPLIT_W < 1) $error("edge_flow_cond: SPLIT_W must be positive");
   end

   generate
      if (DATA_W <= SPLIT_W) begin : g_flat
         assign nonzero = |value;
      end else begin : g_tree
         logic [PAD_W-1:0] padded;
         logic [LANES-1:0] lane_hit;
         assign padded = {{(PAD_W-DATA_W){1'b0}}, value};
         for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign lane_hit[l] = |padded[l*SPLIT_W +: SPLIT_W];
         end
         assign nonzero = |lane_hit;
      end
   endgenerate
endmodule

// File: rtl/edge_flow_next.sv
// Next-PC, next-tag and control decision for one instruction.
module edge_flow_next
   import edge_flow_pkg::*;
#(
   parameter int PC_W  = 16,
   parameter int TAG_W = 8
) (
   input  logic [OP_W-1:0]  op,
   input  logic             cond_nz,
   input  logic [PC_W-1:0]  seq_pc,
   input  logic [PC_W-1:0]  tgt_t,
   input  logic [PC_W-1:0]  tgt_f,
   input  logic [TAG_W-1:0] tag_t,
   input  logic [TAG_W-1:0] tag_f,
   output logic [PC_W-1:0]  nxt_pc,
   output logic [TAG_W-1:0] nxt_tag,
   output flow_ctl_t        ctl
);
   initial begin
      if (PC_W < 2)  $error("edge_flow_next: PC_W too small");
      if (TAG_W < 1) $error("edge_flow_next: TAG_W must be positive");
   end

   flow_op_e kind;
   assign kind = flow_op_e'(op);

   always_comb begin
      nxt_pc  = seq_pc;
      nxt_tag = tag_t;
      ctl     = '{advance: 1'b1, tag_wr: 1'b0, finish: 1'b0, ret_cap: 1'b0};
      unique case (kind)
         FLOW_BR: begin
            ctl.tag_wr = 1'b1;
            if (cond_nz) begin
               nxt_pc  = tgt_t;
               nxt_tag = tag_t;
            end else begin
               nxt_pc  = tgt_f;
               nxt_tag = tag_f;
            end
         end
         FLOW_JMP: begin
            ctl.tag_wr = 1'b1;
            nxt_pc     = tgt_t;
            nxt_tag    = tag_t;
         end
         FLOW_RET: begin
            ctl.advance = 1'b0;
            ctl.finish  = 1'b1;
            ctl.ret_cap = 1'b1;
         end
         FLOW_HALT: begin
            ctl.advance = 1'b0;
            ctl.finish  = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/edge_flow_phi.sv
// PHI source choice from the predecessor tag.
module edge_flow_phi #(
   parameter int TAG_W     = 8,
   parameter int ID_W      = 8,
   parameter bit MISS_TO_A = 1'b1
) (
   input  logic             is_phi,
   input  logic [TAG_W-1:0] cur_tag,
   input  logic [TAG_W-1:0] tag_a,
   input  logic [TAG_W-1:0] tag_b,
   input  logic [ID_W-1:0]  src_a,
   input  logic [ID_W-1:0]  src_b,
   output logic [ID_W-1:0]  sel,
   output logic             miss
);
   initial begin
      if (ID_W < 1) $error("edge_flow_phi: ID_W must be positive");
   end

   logic hit_a, hit_b;
   logic [ID_W-1:0] fallback;

   assign hit_a = (cur_tag == tag_a);
   assign hit_b = (cur_tag == tag_b);

   generate
      if (MISS_TO_A) begin : g_def_a
         assign fallback = src_a;
      end else begin : g_def_b
         assign fallback = src_b;
      end
   endgenerate

   always_comb begin
      if (hit_a)      sel = src_a;
      else if (hit_b) sel = src_b;
      else            sel = fallback;
   end

   assign miss = is_phi & ~hit_a & ~hit_b;
endmodule

// File: rtl/edge_flow_state.sv
// Architectural registers of the unit.
module edge_flow_state
   import edge_flow_pkg::*;
#(
   parameter int PC_W  = 16,
   parameter int TAG_W = 8,
   parameter int ID_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  flow_ctl_t        ctl,
   input  logic [PC_W-1:0]  nxt_pc,
   input  logic [TAG_W-1:0] nxt_tag,
   input  logic [ID_W-1:0]  ret_src,
   output logic [PC_W-1:0]  pc_q,
   output logic [TAG_W-1:0] tag_q,
   output logic             done_q,
   output logic [ID_W-1:0]  ret_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= '0;
         tag_q  <= '0;
         done_q <= 1'b0;
         ret_q  <= '0;
      end else if (accept) begin
         if (ctl.advance) pc_q   <= nxt_pc;
         if (ctl.tag_wr)  tag_q  <= nxt_tag;
         if (ctl.finish)  done_q <= 1'b1;
         if (ctl.ret_cap) ret_q  <= ret_src;
      end
   end
endmodule

// File: rtl/edge_flow_unit.sv
module edge_flow_unit
   import edge_flow_pkg::*;
#(
   parameter int PC_W      = 16,
   parameter int TAG_W     = 8,
   parameter int ID_W      = 8,
   parameter int DATA_W    = 32,
   parameter int SPLIT_W   = 16,
   parameter bit MISS_TO_A = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [3:0]        op,
   input  logic [DATA_W-1:0] cond_value,
   input  logic [PC_W-1:0]   seq_pc,
   input  logic [PC_W-1:0]   tgt_true,
   input  logic [PC_W-1:0]   tgt_false,
   input  logic [TAG_W-1:0]  tag_true,
   input  logic [TAG_W-1:0]  tag_false,
   input  logic [ID_W-1:0]   phi_src_a,
   input  logic [ID_W-1:0]   phi_src_b,
   input  logic [TAG_W-1:0]  phi_tag_a,
   input  logic [TAG_W-1:0]  phi_tag_b,
   input  logic [ID_W-1:0]   ret_src,
   output logic [PC_W-1:0]   pc,
   output logic [TAG_W-1:0]  pred_tag,
   output logic [ID_W-1:0]   phi_src_sel,
   output logic              phi_miss,
   output logic              done,
   output logic [ID_W-1:0]   ret_id
);
   initial begin
      if (OP_W != 4) $error("edge_flow_unit: op port width mismatch");
   end

   logic             cond_nz;
   logic [PC_W-1:0]  nxt_pc;
   logic [TAG_W-1:0] nxt_tag;
   flow_ctl_t        ctl;
   logic             accept;
   logic             is_phi;

   assign accept = instr_valid & ~done;
   assign is_phi = instr_valid & (op == FLOW_PHI);

   edge_flow_cond #(.DATA_W(DATA_W), .SPLIT_W(SPLIT_W)) cond_i (
      .value   (cond_value),
      .nonzero (cond_nz)
   );

   edge_flow_next #(.PC_W(PC_W), .TAG_W(TAG_W)) next_i (
      .op      (op),
      .cond_nz (cond_nz),
      .seq_pc  (seq_pc),
      .tgt_t   (tgt_true),
      .tgt_f   (tgt_false),
      .tag_t   (tag_true),
      .tag_f   (tag_false),
      .nxt_pc  (nxt_pc),
      .nxt_tag (nxt_tag),
      .ctl     (ctl)
   );

   edge_flow_phi #(.TAG_W(TAG_W), .ID_W(ID_W), .MISS_TO_A(MISS_TO_A)) phi_i (
      .is_phi  (is_phi),
      .cur_tag (pred_tag),
      .tag_a   (phi_tag_a),
      .tag_b   (phi_tag_b),
      .src_a   (phi_src_a),
      .src_b   (phi_src_b),
      .sel     (phi_src_sel),
      .miss    (phi_miss)
   );

   edge_flow_state #(.PC_W(PC_W), .TAG_W(TAG_W), .ID_W(ID_W)) state_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .ctl     (ctl),
      .nxt_pc  (nxt_pc),
      .nxt_tag (nxt_tag),
      .ret_src (ret_src),
      .pc_q    (pc),
      .tag_q   (pred_tag),
      .done_q  (done),
      .ret_q   (ret_id)
   );
endmodule

// File: rtl/edge_flow_chk.sv
module edge_flow_chk #(
   parameter int PC_W  = 16,
   parameter int TAG_W = 8,
   parameter int ID_W  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             instr_valid,
   input logic [3:0]       op,
   input logic [PC_W-1:0]  tgt_true,
   input logic [TAG_W-1:0] tag_true,
   input logic [TAG_W-1:0] phi_tag_a,
   input logic [TAG_W-1:0] phi_tag_b,
   input logic [ID_W-1:0]  phi_src_a,
   input logic [ID_W-1:0]  phi_src_b,
   input logic [PC_W-1:0]  pc,
   input logic [TAG_W-1:0] pred_tag,
   input logic [ID_W-1:0]  phi_src_sel,
   input logic             phi_miss,
   input logic             done,
   input logic [ID_W-1:0]  ret_id
);
   a_r3_jump_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !done && op == 4'd2) |=>
         (pc == $past(tgt_true) && pred_tag == $past(tag_true)));

   a_r4_tag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(instr_valid && !done && (op == 4'd1 || op == 4'd2)) |=> $stable(pred_tag));

   a_r5_pick_a: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && op == 4'd4 && pred_tag == phi_tag_a) |-> (phi_src_sel == phi_src_a));

   a_r5_pick_b: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && op == 4'd4 && pred_tag != phi_tag_a && pred_tag == phi_tag_b)
         |-> (phi_src_sel == phi_src_b));

   a_r6_miss_only_phi: assert property (@(posedge clk) disable iff (!rst_n)
      phi_miss |-> (instr_valid && op == 4'd4));

   a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> ($stable(pc) && $stable(pred_tag) && $stable(ret_id)));

   a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |=> ($stable(pc) && $stable(pred_tag) && $stable(done) && $stable(ret_id)));
endmodule

bind edge_flow_unit edge_flow_chk #(.PC_W(PC_W), .TAG_W(TAG_W), .ID_W(ID_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .op          (op),
   .tgt_true    (tgt_true),
   .tag_true    (tag_true),
   .phi_tag_a   (phi_tag_a),
   .phi_tag_b   (phi_tag_b),
   .phi_src_a   (phi_src_a),
   .phi_src_b   (phi_src_b),
   .pc          (pc),
   .pred_tag    (pred_tag),
   .phi_src_sel (phi_src_sel),
   .phi_miss    (phi_miss),
   .done        (done),
   .ret_id      (ret_id)
);

// File: tb/edge_flow_unit_tb_top.sv
module edge_flow_unit_tb_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [3:0]  op = '0;
   logic [31:0] cond_value = '0;
   logic [15:0] seq_pc = '0, tgt_true = '0, tgt_false = '0;
   logic [7:0]  tag_true = '0, tag_false = '0;
   logic [7:0]  phi_src_a = '0, phi_src_b = '0, phi_tag_a = '0, phi_tag_b = '0;
   logic [7:0]  ret_src = '0;
   logic [15:0] pc;
   logic [7:0]  pred_tag, phi_src_sel, ret_id;
   logic        phi_miss, done;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [15:0] pc;
      logic [7:0]  tag;
      logic        done;
      logic [7:0]  ret;
      string       req;
   } exp_t;
   exp_t sb[$];

   logic [15:0] m_pc;
   logic [7:0]  m_tag, m_ret;
   logic        m_done;

   always #(CLK_P/2) clk = ~clk;

   edge_flow_unit dut_i (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .op(op),
      .cond_value(cond_value), .seq_pc(seq_pc), .tgt_true(tgt_true),
      .tgt_false(tgt_false), .tag_true(tag_true), .tag_false(tag_false),
      .phi_src_a(phi_src_a), .phi_src_b(phi_src_b), .phi_tag_a(phi_tag_a),
      .phi_tag_b(phi_tag_b), .ret_src(ret_src), .pc(pc), .pred_tag(pred_tag),
      .phi_src_sel(phi_src_sel), .phi_miss(phi_miss), .done(done), .ret_id(ret_id)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Monitor: compares registered outputs after each edge against the scoreboard.
   initial begin
      forever begin
         @(negedge clk);
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.req, "pc", int'(pc), int'(e.pc));
            check(e.req, "pred_tag", int'(pred_tag), int'(e.tag));
            check(e.req, "done", int'(done), int'(e.done));
            check(e.req, "ret_id", int'(ret_id), int'(e.ret));
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      instr_valid = 1'b0;
      sb.delete();
      @(negedge clk);
      rst_n = 1'b1;
      m_pc = '0; m_tag = '0; m_done = 1'b0; m_ret = '0;
   endtask

   // Driver: applies one instruction, computes the expected state and queues it.
   task automatic issue(input logic vld, input logic [3:0] o, input logic [31:0] c,
                        input logic [15:0] sq, input logic [15:0] tt, input logic [15:0] tf,
                        input logic [7:0] gt, input logic [7:0] gf, input logic [7:0] rs,
                        input string req);
      exp_t e;
      @(negedge clk);
      instr_valid = vld; op = o; cond_value = c; seq_pc = sq;
      tgt_true = tt; tgt_false = tf; tag_true = gt; tag_false = gf; ret_src = rs;
      #2;
      if (vld && !m_done) begin
         case (o)
            4'd1: begin
               m_pc  = (c != 0) ? tt : tf;
               m_tag = (c != 0) ? gt : gf;
            end
            4'd2: begin m_pc = tt; m_tag = gt; end
            4'd3: begin m_done = 1'b1; m_ret = rs; end
            4'd5: m_done = 1'b1;
            default: m_pc = sq;
         endcase
      end
      e.pc = m_pc; e.tag = m_tag; e.done = m_done; e.ret = m_ret; e.req = req;
      sb.push_back(e);
   endtask

   task automatic phi(input logic [7:0] sa, input logic [7:0] sbb, input logic [7:0] ta,
                      input logic [7:0] tb, input logic [15:0] sq, input string req);
      logic [7:0] exp_sel;
      logic       exp_miss;
      phi_src_a = sa; phi_src_b = sbb; phi_tag_a = ta; phi_tag_b = tb;
      issue(1'b1, 4'd4, 32'd0, sq, 16'h0, 16'h0, 8'h0, 8'h0, 8'h0, req);
      exp_miss = (m_tag != ta) && (m_tag != tb);
      exp_sel  = (m_tag == ta) ? sa : ((m_tag == tb) ? sbb : sa);
      check(req, "phi_src_sel", int'(phi_src_sel), int'(exp_sel));
      check(req, "phi_miss", int'(phi_miss), int'(exp_miss));
   endtask

   initial begin
      #(CLK_P * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      #1;
      check("R1", "pc", int'(pc), 0);
      check("R1", "pred_tag", int'(pred_tag), 0);
      check("R1", "done", int'(done), 0);
      check("R1", "ret_id", int'(ret_id), 0);
      // R4 no-op goes sequential
      issue(1'b1, 4'd0, 32'd1, 16'h0003, 16'h0700, 16'h0800, 8'h44, 8'h55, 8'h0, "R4");
      // R2 taken branch
      issue(1'b1, 4'd1, 32'd5, 16'h0010, 16'h1234, 16'h4321, 8'h07, 8'h03, 8'h0, "R2");
      // R5 PHI picks A
      phi(8'd11, 8'd22, 8'h07, 8'h03, 16'h1239, "R5");
      // R2 branch not taken
      issue(1'b1, 4'd1, 32'd0, 16'h0020, 16'h1111, 16'h00A0, 8'h07, 8'h03, 8'h0, "R2");
      // R5 PHI picks B, then both match picks A
      phi(8'd11, 8'd22, 8'h07, 8'h03, 16'h00A7, "R5");
      phi(8'd31, 8'd32, 8'h03, 8'h03, 16'h00AE, "R5");
      // R6 no match: miss and source A
      phi(8'd41, 8'd42, 8'h01, 8'h02, 16'h00B5, "R6");
      // R3 jump with zero condition
      issue(1'b1, 4'd2, 32'd0, 16'h00BC, 16'hBEEF, 16'h2222, 8'h09, 8'h0A, 8'h0, "R3");
      // R4 unused codes go sequential, tag kept
      issue(1'b1, 4'd9, 32'd1, 16'h0055, 16'h3333, 16'h4444, 8'h66, 8'h77, 8'h0, "R4");
      issue(1'b1, 4'd15, 32'd1, 16'h0058, 16'h3333, 16'h4444, 8'h66, 8'h77, 8'h0, "R4");
      // R10 idle cycle with a jump on the fields
      issue(1'b0, 4'd2, 32'd1, 16'h0090, 16'h5555, 16'h6666, 8'h88, 8'h99, 8'h0, "R10");
      // R2 only top condition bit set
      issue(1'b1, 4'd1, 32'h8000_0000, 16'h005B, 16'h0C00, 16'h0D00, 8'h21, 8'h22, 8'h0, "R2");
      // R7 return
      issue(1'b1, 4'd3, 32'd0, 16'h0C03, 16'h0, 16'h0, 8'h0, 8'h0, 8'h2A, "R7");
      // R9 further jump and return ignored
      issue(1'b1, 4'd2, 32'd0, 16'h0C06, 16'hAAAA, 16'h0, 8'h5A, 8'h0, 8'h0, "R9");
      issue(1'b1, 4'd3, 32'd0, 16'h0C09, 16'h0, 16'h0, 8'h0, 8'h0, 8'h3B, "R9");
      @(negedge clk);
      // R8 halt after fresh reset
      do_reset();
      issue(1'b1, 4'd0, 32'd0, 16'h0004, 16'h0, 16'h0, 8'h0, 8'h0, 8'h0, "R4");
      issue(1'b1, 4'd5, 32'd0, 16'h0008, 16'h0, 16'h0, 8'h0, 8'h0, 8'h77, "R8");
      issue(1'b1, 4'd1, 32'd1, 16'h000C, 16'h0F00, 16'h0, 8'h12, 8'h0, 8'h0, "R9");
      @(negedge clk);
      instr_valid = 1'b0;
      repeat (3) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule